// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block recovers characters from an asynchronous serial line. A free-running strobe, `tick16`, pulses sixteen times per bit period. The receiver passes the selected line through a two-flop synchronizer and waits for a falling edge. It confirms the start bit at its midpoint. After that it samples each data bit, the optional parity bit and the first stop bit at their midpoints. Words of 5 to 8 bits are assembled least-significant bit first. Parity may be odd, even or stuck at a constant level.

Each completed character raises `rx_valid` for one clock. At the same time the byte and its parity and framing error flags are presented, and they are held until the next character. A loopback select feeds the local transmitter's output into the receiver in place of the external pin. Reception starts only while both the global enable and the receive enable are high. A character already in progress always runs to completion.

The controller has five states. IDLE goes to START on a synchronized falling edge while enabled. START returns to IDLE (false start) if the line is high at the eighth tick, and otherwise goes to DATA. DATA goes to PARITY after the last data bit when parity is enabled, and otherwise to STOP. PARITY goes to STOP after the parity sample. STOP goes back to IDLE after the stop sample, which is also the cycle that issues the output pulse. Word length and parity settings are captured on the IDLE-to-START transition.

Top module: `uart_frame_rx`

## Requirements
- R1: `word_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits are received least-significant first into `rx_data[0]` upward, and the unused upper bits of `rx_data` are zero.
- R2: With `par_en`=1 and `par_stick`=0, a parity bit follows the data. With `par_even`=1 the data plus parity must hold an even number of ones, and with `par_even`=0 an odd number. A mismatch sets `err_parity`. With `par_en`=0 no parity bit is expected and `err_parity` is 0.
- R3: With `par_en`=1 and `par_stick`=1, the parity bit must equal 0 when `par_even`=1 and 1 when `par_even`=0. Any other value sets `err_parity`.
- R4: A low level at the first stop bit's midpoint sets `err_frame`. Only the first stop bit is examined, so a frame followed by a second stop bit and a frame followed at once by the next start bit are both received without error.
- R5: With `loop_en`=1 the receiver takes its input from `tx_loop`, and activity on `rx_pin` produces no character. With `loop_en`=0 it takes `rx_pin`.
- R6: No character is started unless both `glb_en` and `rx_en` are 1. If an enable drops during a character, that character still completes and is delivered.
- R7: A start bit is accepted only if the synchronized line is still low 8 ticks after the falling edge. A shorter low pulse returns the receiver to IDLE with no output.
- R8: `rx_valid` is a single-cycle pulse. `rx_data`, `err_parity` and `err_frame` change only together with that pulse and hold their values until the next one. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling strobe, 16 per bit period |
| rx_pin | input | 1 | External serial input, idle high |
| tx_loop | input | 1 | Local transmit line used in loopback |
| loop_en | input | 1 | 1 selects `tx_loop` as the receiver input |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| word_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity, or stick level 0 |
| par_stick | input | 1 | Stick parity |
| rx_valid | output | 1 | One-cycle pulse per character |
| rx_data | output | 8 | Received character |
| err_parity | output | 1 | Parity mismatch for this character |
| err_frame | output | 1 | First stop bit sampled low |

## Verification
Random frames cover every word length with random data, random parity mode and occasional flipped parity or stop bits. This separates bit-order, masking and parity-polarity faults: a wrong rule shows up only in some combinations of data weight and mode. Directed frames add four cases. A short low glitch tells a midpoint-checked start from an edge-triggered one. Back-to-back frames with no second stop bit show that only one stop bit is examined. Loopback with a frame driven on the wrong line checks the input mux in both directions. An enable dropped mid-frame tells "finish the character" apart from "abort".

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic [1:0] wlen;
        logic       pen;
        logic       even;
        logic       stick;
    } rx_cfg_t;

endpackage

// File: rtl/uart_rx_front.sv
module uart_rx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic loop_tx,
    input  logic loop_en,
    output logic line,
    output logic fall
);
    logic                   raw;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    assign raw = loop_en ? loop_tx : pin;

    // Idle-high reset values prevent a false edge when reset is released.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign line = sync_q[SYNC_STAGES-1];
    assign fall = prev_q & ~line;
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              even,
    input  logic              stick,
    output logic              exp_bit
);
    // Unused upper data bits are cleared, so the reduction covers the word only.
    always_comb begin
        if (stick)
            exp_bit = ~even;
        else if (even)
            exp_bit = ^data;
        else
            exp_bit = ~(^data);
    end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_pin,
    input  logic              tx_loop,
    input  logic              loop_en,
    input  logic              glb_en,
    input  logic              rx_en,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              par_stick,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              err_parity,
    output logic              err_frame
);
    localparam int TCW      = $clog2(OSR);
    localparam int BCW      = $clog2(DATA_W);
    localparam int HALF     = OSR / 2;
    localparam int MIN_BITS = DATA_W - 3;

    rx_state_t         state_q, state_d;
    rx_cfg_t           cfg_q;
    logic [TCW-1:0]    tcnt_q;
    logic [BCW-1:0]    bcnt_q;
    logic [DATA_W-1:0] shf_q;
    logic              perr_q;
    logic              line, fall, active;
    logic              mid_hit, full_hit, exp_bit;
    logic [BCW-1:0]    last_idx;

    uart_rx_front #(.SYNC_STAGES(2)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (rx_pin),
        .loop_tx (tx_loop),
        .loop_en (loop_en),
        .line    (line),
        .fall    (fall)
    );

    uart_rx_parity #(.DATA_W(DATA_W)) u_parity (
        .data    (shf_q),
        .even    (cfg_q.even),
        .stick   (cfg_q.stick),
        .exp_bit (exp_bit)
    );

    assign active   = glb_en & rx_en;
    assign mid_hit  = tick16 && (tcnt_q == TCW'(HALF - 1));
    assign full_hit = tick16 && (tcnt_q == TCW'(OSR - 1));
    assign last_idx = BCW'(MIN_BITS - 1) + BCW'(cfg_q.wlen);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (active && fall) state_d = ST_START;
            ST_START:  if (mid_hit) state_d = line ? ST_IDLE : ST_DATA;
            ST_DATA:   if (full_hit && bcnt_q == last_idx)
                           state_d = cfg_q.pen ? ST_PARITY : ST_STOP;
            ST_PARITY: if (full_hit) state_d = ST_STOP;
            ST_STOP:   if (full_hit) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register with its counters and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            tcnt_q  <= '0;
            bcnt_q  <= '0;
            shf_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    tcnt_q <= '0;
                    bcnt_q <= '0;
                    if (active && fall) begin
                        cfg_q <= rx_cfg_t'{wlen: word_len, pen: par_en,
                                           even: par_even, stick: par_stick};
                        shf_q <= '0;
                    end
                end
                ST_START: begin
                    if (tick16) tcnt_q <= mid_hit ? '0 : tcnt_q + 1'b1;
                end
                default: begin
                    if (tick16) tcnt_q <= full_hit ? '0 : tcnt_q + 1'b1;
                    if (state_q == ST_DATA && full_hit) begin
                        shf_q[bcnt_q] <= line;
                        bcnt_q        <= bcnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            err_parity <= 1'b0;
            err_frame  <= 1'b0;
            perr_q     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (state_q == ST_IDLE)
                perr_q <= 1'b0;
            if (state_q == ST_PARITY && full_hit)
                perr_q <= line ^ exp_bit;
            if (state_q == ST_STOP && full_hit) begin
                rx_valid   <= 1'b1;
                rx_data    <= shf_q;
                err_parity <= perr_q;
                err_frame  <= ~line;
            end
        end
    end
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick16,
    input logic              glb_en,
    input logic              rx_en,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              err_parity,
    input logic              line,
    input rx_state_t         state_q,
    input rx_cfg_t           cfg_q,
    input logic [$clog2(OSR)-1:0] tcnt_q
);
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R8

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data)); // R8

    AST_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !(glb_en && rx_en)) |=> state_q == ST_IDLE); // R6

    AST_NO_PERR_WITHOUT_PEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_q.pen) |-> !err_parity); // R2

    AST_SHORT_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_q.wlen == 2'd0) |-> rx_data[DATA_W-1:DATA_W-3] == '0); // R1

    AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && tick16 && tcnt_q == ($clog2(OSR))'(OSR/2 - 1) && line)
        |=> state_q == ST_IDLE); // R7
endmodule

bind uart_frame_rx uart_frame_rx_chk #(.DATA_W(DATA_W), .OSR(OSR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick16     (tick16),
    .glb_en     (glb_en),
    .rx_en      (rx_en),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .err_parity (err_parity),
    .line       (line),
    .state_q    (state_q),
    .cfg_q      (cfg_q),
    .tcnt_q     (tcnt_q)
);

// File: tb/uart_frame_rx_bench.sv
`timescale 1ns/1ps
module uart_frame_rx_bench;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic       drv = 1'b1, sel_loop = 1'b0, pin_junk = 1'b0;
    logic       loop_en = 1'b0, glb_en = 1'b1, rx_en = 1'b1;
    logic [1:0] word_len = 2'd3;
    logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
    logic       rx_pin, tx_loop;
    logic       rx_valid, err_parity, err_frame;
    logic [7:0] rx_data;
    logic [1:0] tdiv = 2'd0;

    int total = 0, bad = 0, cap_cnt = 0;
    logic [7:0] cap_d [0:255];
    logic       cap_p [0:255];
    logic       cap_f [0:255];

    always #2.5 clk = ~clk;
    always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick16  = (tdiv == 2'd0);
    assign rx_pin  = sel_loop ? pin_junk : drv;
    assign tx_loop = sel_loop ? drv : 1'b1;

    uart_frame_rx u_uart_frame_rx (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_pin(rx_pin),
        .tx_loop(tx_loop), .loop_en(loop_en), .glb_en(glb_en), .rx_en(rx_en),
        .word_len(word_len), .par_en(par_en), .par_even(par_even),
        .par_stick(par_stick), .rx_valid(rx_valid), .rx_data(rx_data),
        .err_parity(err_parity), .err_frame(err_frame)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            cap_d[cap_cnt % 256] = rx_data;
            cap_p[cap_cnt % 256] = err_parity;
            cap_f[cap_cnt % 256] = err_frame;
            cap_cnt++;
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_word(input logic [7:0] d, input logic [1:0] wl);
        return d & (8'hFF >> (3 - wl));
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input logic even, input logic stick);
        if (stick) return ~even;
        return even ? ^d : ~(^d);
    endfunction

    task automatic drive_bit(input logic b);
        @(negedge clk) drv = b;
        repeat (BITCLK - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        logic [7:0] m;
        m = mask_word(d, word_len);
        drive_bit(1'b0);
        for (int i = 0; i < 5 + int'(word_len); i++) drive_bit(m[i]);
        if (par_en) drive_bit(par_bit(m, par_even, par_stick) ^ bad_par);
        drive_bit(~bad_stop);
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n; i++) drive_bit(1'b1);
    endtask

    task automatic run_frame(input string tag, input logic [7:0] d,
                             input logic bad_par, input logic bad_stop);
        int idx;
        idx = cap_cnt;
        send_frame(d, bad_par, bad_stop);
        idle_bits(2);
        check_eq({tag, " count"}, cap_cnt, idx + 1);
        check_eq({tag, " data"}, cap_d[idx % 256], mask_word(d, word_len));
        check_eq({tag, " perr"}, cap_p[idx % 256], par_en & bad_par);
        check_eq({tag, " ferr"}, cap_f[idx % 256], bad_stop);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int idx;
        void'($urandom(32'd20240611));
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R8 reset valid", rx_valid, 0);
        check_eq("R8 reset data", rx_data, 0);
        check_eq("R8 reset flags", {err_parity, err_frame}, 0);
        idle_bits(1);

        // R1: every word length
        for (int w = 0; w < 4; w++) begin
            word_len = 2'(w);
            run_frame("R1 wlen", 8'hB5, 1'b0, 1'b0);
        end

        // R2: even and odd parity, good and flipped
        word_len = 2'd3; par_en = 1'b1; par_stick = 1'b0;
        par_even = 1'b1; run_frame("R2 even ok", 8'h37, 1'b0, 1'b0);
        par_even = 1'b1; run_frame("R2 even bad", 8'h37, 1'b1, 1'b0);
        par_even = 1'b0; run_frame("R2 odd ok", 8'h36, 1'b0, 1'b0);
        par_even = 1'b0; run_frame("R2 odd bad", 8'h36, 1'b1, 1'b0);

        // R3: stick parity at both levels
        par_stick = 1'b1;
        par_even = 1'b1; run_frame("R3 stick0 ok", 8'hFF, 1'b0, 1'b0);
        par_even = 1'b1; run_frame("R3 stick0 bad", 8'hFF, 1'b1, 1'b0);
        par_even = 1'b0; run_frame("R3 stick1 ok", 8'h00, 1'b0, 1'b0);
        par_even = 1'b0; run_frame("R3 stick1 bad", 8'h00, 1'b1, 1'b0);
        par_stick = 1'b0; par_en = 1'b0;

        // R4: framing error, then back-to-back frames with one stop bit
        run_frame("R4 bad stop", 8'h5A, 1'b0, 1'b1);
        idx = cap_cnt;
        send_frame(8'hC3, 1'b0, 1'b0);
        send_frame(8'h3C, 1'b0, 1'b0);
        idle_bits(2);
        check_eq("R4 b2b count", cap_cnt, idx + 2);
        check_eq("R4 b2b first", {cap_d[idx % 256], cap_f[idx % 256]}, {8'hC3, 1'b0});
        check_eq("R4 b2b second", {cap_d[(idx+1) % 256], cap_f[(idx+1) % 256]}, {8'h3C, 1'b0});

        // R5: loopback takes tx_loop, external pin ignored
        loop_en = 1'b1; sel_loop = 1'b1; pin_junk = 1'b0;
        run_frame("R5 loop rx", 8'h96, 1'b0, 1'b0);
        sel_loop = 1'b0;
        idx = cap_cnt;
        send_frame(8'h11, 1'b0, 1'b0);
        idle_bits(2);
        check_eq("R5 pin ignored", cap_cnt, idx);
        loop_en = 1'b0;

        // R6: disabled receiver, then enable dropped mid-character
        rx_en = 1'b0;
        idx = cap_cnt;
        send_frame(8'h77, 1'b0, 1'b0);
        idle_bits(2);
        check_eq("R6 disabled", cap_cnt, idx);
        rx_en = 1'b1;
        idx = cap_cnt;
        fork
            send_frame(8'hE1, 1'b0, 1'b0);
            begin repeat (BITCLK * 3) @(negedge clk); glb_en = 1'b0; end
        join
        idle_bits(2);
        check_eq("R6 finish count", cap_cnt, idx + 1);
        check_eq("R6 finish data", cap_d[idx % 256], 8'hE1);
        glb_en = 1'b1;

        // R7: short glitch rejected, following frame intact
        idx = cap_cnt;
        @(negedge clk) drv = 1'b0;
        repeat (12) @(negedge clk);
        drv = 1'b1;
        idle_bits(2);
        check_eq("R7 glitch", cap_cnt, idx);
        run_frame("R7 after glitch", 8'h4D, 1'b0, 1'b0);

        // Random frames across R1 R2 R3 R4
        for (int k = 0; k < 40; k++) begin
            logic [7:0] d;
            logic bp, bs;
            d = 8'($urandom);
            word_len = 2'($urandom % 4);
            par_en = 1'($urandom % 2);
            par_even = 1'($urandom % 2);
            par_stick = 1'($urandom % 2);
            bp = ($urandom % 4) == 0;
            bs = ($urandom % 5) == 0;
            run_frame("R1 R2 R3 R4 random", d, bp, bs);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule